// File: doc/BRIEF.md
# Fixed-Point Cascaded Second-Order Low-Pass Filter

This block is a streaming low-pass filter built from a chain of second-order recursive sections. It works in signed fixed-point. Every section holds three forward taps and two feedback taps, plus two delay registers in the canonical single-delay-line arrangement. Each section's output becomes the next section's input, and the last section drives the result port. Two sections give a fourth-order response.

Taps carry `SHIFT` fractional bits, so the value 2^SHIFT stands for 1.0. After each accumulation an arithmetic right shift by `SHIFT` restores the data scale, with round-to-nearest. Values that do not fit the data width are handled by the `SATURATE` parameter. When it is set, they clamp to the extreme representable value. When it is clear, the upper bits are dropped.

One multiplier is shared by every product of every section. A sample is taken on a valid/ready handshake and the result leaves on another. A tap is set to zero to prune it: the multiplier operands are then held at zero for that step, so the tap adds nothing. Taps start from a parameter and can be rewritten through a small load port while the filter is idle.

A finite-state machine sequences the work. Its states are:

- `ST_IDLE`: waiting for a sample. On an accepted sample it goes to `ST_FB1`.
- `ST_FB1`, then `ST_FB2`: subtract the two feedback products.
- `ST_WRED`: reduce the sum into the new delay value w.
- `ST_FF0`, `ST_FF1`, `ST_FF2`: accumulate the three forward products.
- `ST_YRED`: reduce the forward sum and shift the section's delays. It returns to `ST_FB1` for the next section, or goes to `ST_OUT` after the last section.
- `ST_OUT`: present the result. It goes back to `ST_IDLE` once `out_ready` is high.

Top module: `sos_lowpass`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every delay register to zero and returns the block to `ST_IDLE`. In the cycle after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: For each section, with delays w1 and w2, the block computes w = round(x·2^SHIFT − a1·w1 − a2·w2) and y = round(b0·w + b1·w1 + b2·w2). It then updates w2 ← w1 and w1 ← w.
- R3: The output of section k is the input of section k+1. `out_data` is the output of the last section.
- R4: round(v) is (v + 2^(SHIFT−1)) >>> SHIFT, an arithmetic shift. With the default SHIFT = 14, a tap of 16384 means 1.0. The accumulator is 2·16+3 bits wide, so sums inside a section never wrap.
- R5: With SATURATE=1, a rounded value above 32767 becomes 32767 and a value below −32768 becomes −32768. This applies to both w and y.
- R6: With SATURATE=0, a rounded value keeps only its low 16 bits, read as signed.
- R7: A tap equal to zero adds nothing to its sum, and the multiplier operands stay zero for that step.
- R8: `in_ready` is high only in `ST_IDLE`. `out_valid` is high only in `ST_OUT`. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R9: `out_valid` rises exactly 7·NUM_SEC clock edges after the edge that accepts a sample. With the default NUM_SEC = 2, that is 14 edges.
- R10: A tap write (`cfg_we`) in `ST_IDLE` replaces tap `cfg_tap` of section `cfg_sec`, using the encoding 0=b0, 1=b1, 2=b2, 3=a1, 4=a2. A write in any other state is ignored. So is a write with a tap code of 5 or more, or a section index of NUM_SEC or more.
- R11: Reset restores every tap to the value given in `DEF_COEF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Filtered result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Signed filtered result |
| cfg_we | input | 1 | Tap write strobe |
| cfg_sec | input | SEC_W | Section index of the write |
| cfg_tap | input | 3 | Tap code: 0=b0, 1=b1, 2=b2, 3=a1, 4=a2 |
| cfg_coef | input | COEF_W | Signed tap value |

## Verification
A unit impulse separates the feedback recursion from the forward path, because the later terms come only from the delay line. A small step tests the accumulated DC behaviour and the rounding over many samples.

A full-scale input on a doubled single-tap section makes the saturating and wrapping builds give opposite signs. Random taps, with about a third of them pruned to zero, against random samples cover the general datapath. A saturating and a wrapping instance run side by side against a bit-exact integer model.

Writes during a busy computation, a reset after reloading taps, and a held `out_ready` test the load port, the default restore and the output hold.

// File: rtl/sos_pkg.sv
package sos_pkg;

    localparam int TAPS   = 5;
    localparam int TAP_B0 = 0;
    localparam int TAP_B1 = 1;
    localparam int TAP_B2 = 2;
    localparam int TAP_A1 = 3;
    localparam int TAP_A2 = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FB1,
        ST_FB2,
        ST_WRED,
        ST_FF0,
        ST_FF1,
        ST_FF2,
        ST_YRED,
        ST_OUT
    } sos_state_e;

endpackage

// File: rtl/sos_coef_bank.sv
module sos_coef_bank
    import sos_pkg::*;
#(
    parameter int NUM_SEC = 2,
    parameter int COEF_W  = 16,
    parameter int SEC_W   = 1,
    parameter logic [NUM_SEC*TAPS*COEF_W-1:0] DEF_COEF = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SEC_W-1:0]         wr_sec,
    input  logic [2:0]               wr_tap,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic [SEC_W-1:0]         rd_sec,
    input  logic [2:0]               rd_tap,
    output logic signed [COEF_W-1:0] rd_coef
);
    localparam int ENTRIES = NUM_SEC * TAPS;

    logic signed [COEF_W-1:0] mem [ENTRIES];

    // One register per tap; a write lands only on an in-range slot.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_tap
        localparam int SEC = e / TAPS;
        localparam int TAP = e % TAPS;
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[e] <= DEF_COEF[e*COEF_W +: COEF_W];
            end else if (wr_en && (int'(wr_sec) == SEC) && (int'(wr_tap) == TAP)) begin
                mem[e] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_coef = '0;
        if ((int'(rd_sec) < NUM_SEC) && (int'(rd_tap) < TAPS)) begin
            rd_coef = mem[int'(rd_sec) * TAPS + int'(rd_tap)];
        end
    end

endmodule

// File: rtl/sos_delay_bank.sv
module sos_delay_bank #(
    parameter int NUM_SEC = 2,
    parameter int DATA_W  = 16,
    parameter int SEC_W   = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd,
    input  logic [SEC_W-1:0]         sec,
    input  logic signed [DATA_W-1:0] w_new,
    output logic signed [DATA_W-1:0] w1,
    output logic signed [DATA_W-1:0] w2
);
    logic signed [DATA_W-1:0] d1 [NUM_SEC];
    logic signed [DATA_W-1:0] d2 [NUM_SEC];

    for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
        always_ff @(posedge clk) begin
            if (rst) begin
                d1[s] <= '0;
                d2[s] <= '0;
            end else if (upd && (int'(sec) == s)) begin
                d2[s] <= d1[s];
                d1[s] <= w_new;
            end
        end
    end

    always_comb begin
        w1 = '0;
        w2 = '0;
        if (int'(sec) < NUM_SEC) begin
            w1 = d1[int'(sec)];
            w2 = d2[int'(sec)];
        end
    end

endmodule

// File: rtl/sos_mac.sv
module sos_mac #(
    parameter int COEF_W = 16,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 35
) (
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [DATA_W-1:0] data,
    input  logic                     sub,
    input  logic signed [ACC_W-1:0]  acc_in,
    output logic signed [ACC_W-1:0]  acc_out
);
    localparam int PROD_W = COEF_W + DATA_W;

    logic                     pruned;
    logic signed [COEF_W-1:0] c_op;
    logic signed [DATA_W-1:0] d_op;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_x;

    // A zero tap keeps both operands at zero: no toggling in the multiplier.
    assign pruned = (coef == '0);
    assign c_op   = pruned ? '0 : coef;
    assign d_op   = pruned ? '0 : data;
    assign prod   = c_op * d_op;
    assign prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign acc_out = sub ? (acc_in - prod_x) : (acc_in + prod_x);

endmodule

// File: rtl/sos_reduce.sv
module sos_reduce #(
    parameter int ACC_W    = 35,
    parameter int DATA_W   = 16,
    parameter int SHIFT    = 14,
    parameter bit SATURATE = 1'b1
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    output logic signed [DATA_W-1:0] q_out
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SHIFT - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (DATA_W - 1));

    logic signed [ACC_W-1:0] rounded;
    logic signed [ACC_W-1:0] scaled;

    assign rounded = acc_in + HALF;
    assign scaled  = rounded >>> SHIFT;

    if (SATURATE) begin : g_sat
        always_comb begin
            if (scaled > MAXV)      q_out = MAXV[DATA_W-1:0];
            else if (scaled < MINV) q_out = MINV[DATA_W-1:0];
            else                    q_out = scaled[DATA_W-1:0];
        end
    end else begin : g_wrap
        assign q_out = scaled[DATA_W-1:0];
    end

endmodule

// File: rtl/sos_lowpass.sv
module sos_lowpass
    import sos_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int COEF_W   = 16,
    parameter int NUM_SEC  = 2,
    parameter int SHIFT    = 14,
    parameter bit SATURATE = 1'b1,
    parameter int SEC_W    = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1,
    parameter logic [NUM_SEC*TAPS*COEF_W-1:0] DEF_COEF = {
        16'(6000), 16'(-20000), 16'(596), 16'(1192), 16'(596),
        16'(9000), 16'(-24000), 16'(344), 16'(688),  16'(344)
    }
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [DATA_W-1:0] out_data,
    input  logic                     cfg_we,
    input  logic [SEC_W-1:0]         cfg_sec,
    input  logic [2:0]               cfg_tap,
    input  logic signed [COEF_W-1:0] cfg_coef
);
    localparam int ACC_W = DATA_W + COEF_W + 3;

    sos_state_e state, state_nx;

    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  mac_out;
    logic signed [DATA_W-1:0] w_reg;
    logic signed [DATA_W-1:0] red_out;
    logic signed [DATA_W-1:0] w1, w2;
    logic signed [DATA_W-1:0] mul_data;
    logic signed [COEF_W-1:0] coef;
    logic [2:0]               tap_sel;
    logic                     mul_sub;
    logic [SEC_W-1:0]         sec_idx;
    logic                     last_sec;
    logic                     cfg_ok;

    assign last_sec = (int'(sec_idx) == NUM_SEC - 1);
    assign cfg_ok   = cfg_we && (state == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_FB1;
            ST_FB1:  state_nx = ST_FB2;
            ST_FB2:  state_nx = ST_WRED;
            ST_WRED: state_nx = ST_FF0;
            ST_FF0:  state_nx = ST_FF1;
            ST_FF1:  state_nx = ST_FF2;
            ST_FF2:  state_nx = ST_YRED;
            ST_YRED: state_nx = last_sec ? ST_OUT : ST_FB1;
            ST_OUT:  if (out_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_OUT);
    end

    // Multiplier operand selection per step
    always_comb begin
        tap_sel  = 3'd7;
        mul_data = '0;
        mul_sub  = 1'b0;
        unique case (state)
            ST_FB1: begin tap_sel = 3'(TAP_A1); mul_data = w1;    mul_sub = 1'b1; end
            ST_FB2: begin tap_sel = 3'(TAP_A2); mul_data = w2;    mul_sub = 1'b1; end
            ST_FF0: begin tap_sel = 3'(TAP_B0); mul_data = w_reg; end
            ST_FF1: begin tap_sel = 3'(TAP_B1); mul_data = w1;    end
            ST_FF2: begin tap_sel = 3'(TAP_B2); mul_data = w2;    end
            default: ;
        endcase
    end

    sos_coef_bank #(
        .NUM_SEC (NUM_SEC),
        .COEF_W  (COEF_W),
        .SEC_W   (SEC_W),
        .DEF_COEF(DEF_COEF)
    ) u_coef (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_ok),
        .wr_sec (cfg_sec),
        .wr_tap (cfg_tap),
        .wr_data(cfg_coef),
        .rd_sec (sec_idx),
        .rd_tap (tap_sel),
        .rd_coef(coef)
    );

    sos_delay_bank #(
        .NUM_SEC(NUM_SEC),
        .DATA_W (DATA_W),
        .SEC_W  (SEC_W)
    ) u_delay (
        .clk  (clk),
        .rst  (rst),
        .upd  (state == ST_YRED),
        .sec  (sec_idx),
        .w_new(w_reg),
        .w1   (w1),
        .w2   (w2)
    );

    sos_mac #(
        .COEF_W(COEF_W),
        .DATA_W(DATA_W),
        .ACC_W (ACC_W)
    ) u_mac (
        .coef   (coef),
        .data   (mul_data),
        .sub    (mul_sub),
        .acc_in (acc),
        .acc_out(mac_out)
    );

    sos_reduce #(
        .ACC_W   (ACC_W),
        .DATA_W  (DATA_W),
        .SHIFT   (SHIFT),
        .SATURATE(SATURATE)
    ) u_red (
        .acc_in(acc),
        .q_out (red_out)
    );

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            w_reg    <= '0;
            sec_idx  <= '0;
            out_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (in_valid) begin
                    acc     <= {{(ACC_W-DATA_W){in_data[DATA_W-1]}}, in_data} <<< SHIFT;
                    sec_idx <= '0;
                end
                ST_FB1, ST_FB2, ST_FF0, ST_FF1, ST_FF2: acc <= mac_out;
                ST_WRED: begin
                    w_reg <= red_out;
                    acc   <= '0;
                end
                ST_YRED: begin
                    if (last_sec) begin
                        out_data <= red_out;
                    end else begin
                        acc     <= {{(ACC_W-DATA_W){red_out[DATA_W-1]}}, red_out} <<< SHIFT;
                        sec_idx <= sec_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sos_lowpass_chk.sv
module sos_lowpass_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid)); // R1

    AST_HANDSHAKE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R8

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && !out_valid)); // R9

    AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid)); // R8

endmodule

bind sos_lowpass sos_lowpass_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/sim_sos_lowpass.sv
module sim_sos_lowpass;
    localparam int NSEC  = 2;
    localparam int SHF   = 14;
    localparam int LAT   = 7 * NSEC;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic signed [15:0] in_data;
    logic        out_ready;
    logic        cfg_we;
    logic [0:0]  cfg_sec;
    logic [2:0]  cfg_tap;
    logic signed [15:0] cfg_coef;
    logic        rdy0, rdy1, ov0, ov1;
    logic signed [15:0] od0, od1;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    // Bench copy of taps and delays: [mode 0 = saturate, 1 = wrap][section]
    longint cf [NSEC][5];
    longint mw1 [2][NSEC];
    longint mw2 [2][NSEC];

    always #2.5 clk = ~clk;

    sos_lowpass #(.SATURATE(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy0), .in_data(in_data),
        .out_valid(ov0), .out_ready(out_ready), .out_data(od0),
        .cfg_we(cfg_we), .cfg_sec(cfg_sec), .cfg_tap(cfg_tap), .cfg_coef(cfg_coef));

    sos_lowpass #(.SATURATE(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy1), .in_data(in_data),
        .out_valid(ov1), .out_ready(out_ready), .out_data(od1),
        .cfg_we(cfg_we), .cfg_sec(cfg_sec), .cfg_tap(cfg_tap), .cfg_coef(cfg_coef));

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
                report();
                $finish;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint rnd(input longint v, input int mode);
        longint r;
        r = (v + (longint'(1) <<< (SHF - 1))) >>> SHF;
        if (mode == 0) begin
            if (r > 32767) r = 32767;
            else if (r < -32768) r = -32768;
        end else begin
            r = longint'(shortint'(r[15:0]));
        end
        return r;
    endfunction

    function automatic longint model_step(input int mode, input longint x);
        longint xv, acc, w, y;
        xv = x;
        for (int s = 0; s < NSEC; s++) begin
            acc = (xv <<< SHF) - cf[s][3] * mw1[mode][s] - cf[s][4] * mw2[mode][s];
            w   = rnd(acc, mode);
            acc = cf[s][0] * w + cf[s][1] * mw1[mode][s] + cf[s][2] * mw2[mode][s];
            y   = rnd(acc, mode);
            mw2[mode][s] = mw1[mode][s];
            mw1[mode][s] = w;
            xv = y;
        end
        return xv;
    endfunction

    task automatic load_defaults();
        cf[0][0] = 344; cf[0][1] = 688;  cf[0][2] = 344; cf[0][3] = -24000; cf[0][4] = 9000;
        cf[1][0] = 596; cf[1][1] = 1192; cf[1][2] = 596; cf[1][3] = -20000; cf[1][4] = 6000;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        load_defaults();
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < NSEC; s++) begin mw1[m][s] = 0; mw2[m][s] = 0; end
    endtask

    // Tap write while idle; bench copy follows (R10)
    task automatic write_tap(input int s, input int t, input longint v);
        @(negedge clk);
        while (!rdy0) @(negedge clk);
        cfg_we = 1'b1; cfg_sec = 1'(s); cfg_tap = 3'(t); cfg_coef = 16'(v);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (s < NSEC && t < 5) cf[s][t] = v;
    endtask

    task automatic run_sample(input longint x, input string req, input bit poke, input bit hold);
        longint e0, e1;
        int lat;
        logic signed [15:0] keep;
        e0 = model_step(0, x);
        e1 = model_step(1, x);
        @(negedge clk);
        while (!rdy0) @(negedge clk);
        out_ready = !hold;
        in_valid = 1'b1; in_data = 16'(x);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0;
        if (poke) begin
            // R10: write during computation must be ignored
            cfg_we = 1'b1; cfg_sec = 1'b0; cfg_tap = 3'd0; cfg_coef = 16'sd12345;
        end
        while (!ov0 && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
            lat++;
        end
        chk(lat == LAT, "R9 latency", lat, LAT);
        chk(ov0 && longint'(od0) == e0, {req, " saturate"}, longint'(od0), e0);
        chk(ov1 && longint'(od1) == e1, {req, " wrap"}, longint'(od1), e1);
        if (hold) begin
            keep = od0;
            for (int k = 0; k < 4; k++) begin
                @(posedge clk);
                @(negedge clk);
                chk(ov0 && od0 == keep && !rdy0, "R8 hold under backpressure", longint'(od0), longint'(keep));
            end
            out_ready = 1'b1;
        end
        @(posedge clk);
    endtask

    initial begin
        longint v;
        void'($urandom(32'd4711));
        rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
        cfg_we = 1'b0; cfg_sec = '0; cfg_tap = '0; cfg_coef = '0;
        do_reset();

        // R1: reset state
        chk(rdy0 && !ov0 && rdy1 && !ov1, "R1 reset handshake", {ov0, rdy0}, 1);

        // R2/R3/R4: unit impulse on default taps
        run_sample(8192, "R2 R3 impulse", 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) run_sample(0, "R2 R4 impulse tail", 1'b0, 1'b0);

        // R4: small step
        for (int i = 0; i < 30; i++) run_sample(1000, "R4 step", 1'b0, 1'b0);

        // R8: backpressure
        run_sample(-700, "R8 held sample", 1'b0, 1'b1);

        // R10: busy write ignored, idle write applied
        run_sample(500, "R10 busy write", 1'b1, 1'b0);
        run_sample(-300, "R10 after busy write", 1'b0, 1'b0);
        write_tap(1, 7, 999);  // bad tap code, ignored
        run_sample(250, "R10 bad tap code", 1'b0, 1'b0);

        // R5/R6/R7: full scale on doubled single-tap section, pruned taps
        write_tap(0, 0, 32767); write_tap(0, 1, 0); write_tap(0, 2, 0);
        write_tap(0, 3, 0);     write_tap(0, 4, 0);
        write_tap(1, 0, 16384); write_tap(1, 1, 0); write_tap(1, 2, 0);
        write_tap(1, 3, 0);     write_tap(1, 4, 0);
        run_sample(32767, "R5 R6 R7 full scale", 1'b0, 1'b0);
        chk(od0 == 16'sd32767, "R5 clamp positive", longint'(od0), 32767);
        chk(od1 < 0, "R6 wrap flips sign", longint'(od1), -4);
        run_sample(-32768, "R5 R6 R7 negative full scale", 1'b0, 1'b0);
        chk(od0 == -16'sd32768, "R5 clamp negative", longint'(od0), -32768);
        chk(od1 > 0, "R6 wrap flips sign negative", longint'(od1), 2);

        // R11: reset restores default taps and clears delays
        do_reset();
        run_sample(8192, "R11 default taps after reset", 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) run_sample(0, "R11 R1 tail", 1'b0, 1'b0);

        // Random taps (about a third pruned) and random samples
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < NSEC; s++)
                for (int t = 0; t < 5; t++) begin
                    if ($urandom_range(0, 2) == 0) v = 0;
                    else v = longint'(shortint'($urandom_range(0, 65535))) / 2;
                    write_tap(s, t, v);
                end
            for (int i = 0; i < 40; i++)
                run_sample(longint'(shortint'($urandom_range(0, 65535))), "R2 R7 random", 1'b0, 1'b0);
        end

        report();
        $finish;
    end

endmodule